// File: doc/BRIEF.md
# Line Period Measurement Counter

This block measures the period of the voltage line. It counts the pulses of a slow timebase enable between two successive positive-going zero crossings. Each enable pulse stands for one 3.90625 µs tick of a 256 kHz timebase. A 50 Hz line therefore reads about 5120, and a 60 Hz line reads about 4267. When the line is steady, successive readings differ by no more than one count.

The surrounding logic supplies a one-cycle strobe for each rising zero crossing and a one-cycle tick enable at the timebase rate. Both are synchronous to the system clock. The block keeps a running count of ticks. On each strobe it copies the count of the period that has just ended into a 16-bit output register and starts the next period from zero. The count stops at all-ones, so a line slower than about 3.9 Hz, or a line that has gone missing, still gives a defined reading.

Top module: `line_period_meter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `period_o` reads 0.
- R2: After reset, the first zero-crossing strobe leaves `period_o` at 0, because no complete period has been seen yet.
- R3: On each later strobe, `period_o` takes the number of tick-enable cycles in the window that starts after the previous strobe and includes the strobe cycle itself. The new value is visible from the clock edge that samples the strobe.
- R4: Clock cycles with `tick_en` low add nothing to the count, however many of them fall between ticks.
- R5: A tick in the same cycle as a strobe belongs to the period that ends there. The next period starts counting from zero, so two strobes with no tick between them read 0, or 1 if the second strobe carries a tick.
- R6: The running count stops at 0xFFFF. A period with 65535 or more ticks reads 0xFFFF.
- R7: Between strobes, `period_o` holds its value whatever `tick_en` does.
- R8: A saturated period does not affect the next one. The period after it is measured from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle enable, one per 256 kHz timebase tick |
| zc_strobe | input | 1 | One-cycle strobe on a positive-going zero crossing |
| period_o | output | 16 | Ticks in the last complete line period, unsigned |

## Verification
A timebase tick and a zero-crossing strobe can arrive in the same clock cycle. In that cycle the block must add the tick to the period that is closing and also restart the counter from zero. The stimulus table has rows that raise `tick_en` together with the strobe, including a pair of back-to-back strobes. The expected readings (one higher than the matching rows without the coincident tick, and a plain 1 for the back-to-back pair) show whether that tick went to the closing period, was dropped, or leaked into the next one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Capture-side state: no crossing seen yet, or a period window is open.
    typedef enum logic {
        LPM_WAIT_FIRST = 1'b0,
        LPM_MEASURING  = 1'b1
    } lpm_phase_e;

    localparam int LPM_DEFAULT_CNT_W = 16;

endpackage

// File: rtl/lpm_tick_counter.sv
module lpm_tick_counter #(
    parameter int CNT_W = lpm_pkg::LPM_DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             restart,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] closing_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] with_tick;
    logic             at_max;

    always_comb begin
        at_max    = (st_q.count == CNT_MAX);
        // A tick in this cycle is added to the period that is currently open.
        with_tick = (tick_en && !at_max) ? st_q.count + 1'b1 : st_q.count;
        st_d      = st_q;
        if (restart) begin
            st_d.count = '0;
        end else begin
            st_d.count = with_tick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign closing_o = with_tick;

endmodule

// File: rtl/lpm_capture.sv
module lpm_capture #(
    parameter int CNT_W = lpm_pkg::LPM_DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zc_strobe,
    input  logic [CNT_W-1:0] closing_i,
    output logic [CNT_W-1:0] period_o,
    output logic             armed_o
);

    import lpm_pkg::*;

    typedef struct packed {
        lpm_phase_e       phase;
        logic [CNT_W-1:0] period;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (zc_strobe) begin
            // The first crossing only opens a window; later ones close it.
            if (st_q.phase == LPM_MEASURING) begin
                st_d.period = closing_i;
            end
            st_d.phase = LPM_MEASURING;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= LPM_WAIT_FIRST;
            st_q.period <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_o = st_q.period;
    assign armed_o  = (st_q.phase == LPM_MEASURING);

endmodule

// File: rtl/line_period_meter.sv
module line_period_meter #(
    parameter int CNT_W = lpm_pkg::LPM_DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             zc_strobe,
    output logic [CNT_W-1:0] period_o
);

    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] closing_w;
    logic             armed_w;

    lpm_tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .restart   (zc_strobe),
        .count_o   (count_w),
        .closing_o (closing_w)
    );

    lpm_capture #(.CNT_W(CNT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_strobe (zc_strobe),
        .closing_i (closing_w),
        .period_o  (period_o),
        .armed_o   (armed_w)
    );

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             zc_strobe,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] count,
    input logic             armed
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Period expected from the counter state and tick of the previous cycle.
    logic [CNT_W-1:0] prev_count;
    logic             prev_tick;
    logic [CNT_W-1:0] expect_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_count <= '0;
            prev_tick  <= 1'b0;
        end else begin
            prev_count <= count;
            prev_tick  <= tick_en;
        end
    end

    assign expect_cap = (prev_count == CNT_MAX) ? CNT_MAX
                                                : prev_count + {{(CNT_W-1){1'b0}}, prev_tick};

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (period_o == '0));

    assert_unarmed_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (period_o == '0));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && zc_strobe) |=> (period_o == expect_cap));

    assert_no_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !zc_strobe) |=> $stable(count));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        zc_strobe |=> (count == '0));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == CNT_MAX) && !zc_strobe) |=> (count == CNT_MAX));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_strobe |=> $stable(period_o));

endmodule

bind line_period_meter lpm_checker #(.CNT_W(CNT_W)) u_lpm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .zc_strobe (zc_strobe),
    .period_o  (period_o),
    .count     (count_w),
    .armed     (armed_w)
);

// File: tb/line_period_meter_test.sv
module line_period_meter_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int N_VEC = 7;
    localparam int WATCHDOG_CYCLES = 190000;

    // Per row: ticks in the period, idle cycles after each tick,
    // tick raised together with the strobe, expected reading.
    localparam int VEC_TICKS [N_VEC] = '{5120, 4267, 10, 0, 0, 1, 12};
    localparam int VEC_GAP   [N_VEC] = '{0,    1,    3,  0, 0, 2, 5};
    localparam int VEC_COTCK [N_VEC] = '{0,    0,    1,  0, 1, 0, 1};
    localparam int VEC_EXP   [N_VEC] = '{5120, 4267, 11, 0, 1, 1, 13};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         zc_strobe = 1'b0;
    logic [W-1:0] period_o;

    int checks = 0;
    int errors = 0;

    line_period_meter #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .zc_strobe (zc_strobe),
        .period_o  (period_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive inputs on the falling edge, look at outputs just after the rising edge.
    task automatic step(input logic tk, input logic zc);
        @(negedge clk);
        tick_en   = tk;
        zc_strobe = zc;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_period(input string req, input int exp);
        checks++;
        if (period_o !== W'(exp)) begin
            errors++;
            $display("FAIL %s: period_o actual=%0d expected=%0d", req, period_o, exp);
        end
    endtask

    task automatic run_period(input int ticks, input int gap, input logic cotick);
        for (int k = 0; k < ticks; k++) begin
            step(1'b1, 1'b0);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
        end
        step(cotick, 1'b1);
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(posedge clk);
        #1;
        expect_period("R1 in reset", 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        expect_period("R1 after release", 0);

        // Ticks before any crossing, then the first crossing.
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        expect_period("R2 first crossing", 0);

        // Table walk (R3 count, R4 idle gaps, R5 coincident tick and back-to-back).
        prev = 0;
        for (int v = 0; v < N_VEC; v++) begin
            for (int k = 0; k < VEC_TICKS[v]; k++) begin
                step(1'b1, 1'b0);
                for (int g = 0; g < VEC_GAP[v]; g++) step(1'b0, 1'b0);
                if (k == VEC_TICKS[v] / 2) expect_period("R7 hold mid-period", prev);
            end
            step(VEC_COTCK[v] != 0, 1'b1);
            expect_period((VEC_COTCK[v] != 0) ? "R5 tick with strobe" :
                          (VEC_GAP[v] != 0) ? "R4 idle cycles" : "R3 period count",
                          VEC_EXP[v]);
            prev = VEC_EXP[v];
        end

        // Long idle stretch without ticks: R7 holds.
        for (int k = 0; k < 50; k++) step(1'b0, 1'b0);
        expect_period("R7 idle hold", prev);

        // Saturation.
        run_period(70000, 0, 1'b0);
        expect_period("R6 saturated reading", 16'hFFFF);
        run_period(3, 0, 1'b0);
        expect_period("R8 after saturation", 3);

        // Exactly at the limit.
        run_period(65535, 0, 1'b0);
        expect_period("R6 at limit", 16'hFFFF);
        run_period(2, 1, 1'b1);
        expect_period("R8 recovered", 3);

        // Reset in the middle of a period.
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        expect_period("R1 mid-run reset", 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        expect_period("R2 first crossing after reset", 0);
        run_period(7, 0, 1'b0);
        expect_period("R3 after reset", 7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule